// File: doc/BRIEF.md
# Write-Status Read Multiplexer

This block sits on the read path of a flash-style array and decides, for every read access, whether the host sees real array contents or a status word. A command sequencer outside the block reports the current write state through a two-bit mode code. It also reports whether an erase is suspended, and which sector or block that suspended erase targets. The block returns data-polling and toggle status while an internal program or erase runs. It keeps returning array data for reads outside a suspended erase region, and it drives a ready/busy output for hardware polling.

Toggle status advances once per read access, not once per clock. A read access begins on the clock where the read strobe is first seen high, after being low on the previous clock. Holding the strobe high across several clocks returns one stable word. Two independent toggle flops are kept: one for reads during an active operation, and one for reads that land inside a suspended erase region. Each advances only on accesses of its own kind.

Top module: `wstat_rdmux`

## Requirements
- R1: The mode input uses these codes: 0 for idle, 1 for an active operation, 2 for erase suspended, and 3, which is treated as idle. In idle, every clock edge with `rd_en_i` high captures `array_data_i` into `rd_data_o`, so the word appears one clock later.
- R2: In mode 1, every address returns a status word, whatever its region, and bit 7 of that word is the complement of `exp_d7_i`.
- R3: In mode 1, bit 6 of the status word holds the active toggle. The first active access after reset returns 1, and each later active access returns the inverse of the previous one. The value stays constant while `rd_en_i` is held high.
- R4: An active status word has every bit other than bits 7 and 6 at zero, including bit 2.
- R5: In mode 2, a read inside the suspended region returns a word with bit 6 at 1 and bit 2 holding the suspend toggle. That toggle reads 1 on its first access and inverts on each later in-region access. All other bits are zero.
- R6: In mode 2, a read outside the suspended region returns `array_data_i`.
- R7: The region test compares only the address bits above the region size. With `susp_blk_i`=1, bits 19..15 of `rd_addr_i` are compared with those of `susp_base_i` (32K-word blocks). With `susp_blk_i`=0, bits 19..11 are compared (2K-word sectors).
- R8: `ready_o` is low exactly while mode is 1, in the same cycle as the mode code, and it is high in every other mode.
- R9: Reset clears `rd_data_o` to zero. While `rd_en_i` is low, `rd_data_o` holds its last value.
- R10: Reads in idle or suspended mode do not advance the active toggle, and active reads do not advance the suspend toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Write-state code from the sequencer |
| exp_d7_i | input | 1 | Bit 7 of the data expected once the operation completes |
| susp_base_i | input | AW | Any address inside the suspended region |
| susp_blk_i | input | 1 | 1: the suspended region is a block, 0: it is a sector |
| rd_en_i | input | 1 | Read strobe (output enable qualified by chip enable) |
| rd_addr_i | input | AW | Read address |
| array_data_i | input | DW | Array contents at `rd_addr_i` |
| rd_data_o | output | DW | Registered read word |
| ready_o | output | 1 | High when no operation is active |

## Verification
The assertions take for granted that the sequencer changes the mode code only between accesses. They also assume that `exp_d7_i` stays steady during an access, so that a held strobe should yield one unchanged word. The stimulus changes mode, polarity, region base and size only while the strobe is low, with an idle clock on each side. It drives each read for one or more clocks and then drops the strobe for at least one clock, so that every access has a clean rising edge. The address sweeps are built arithmetically across sectors and blocks, so that the in-region and out-of-region outcomes are known in advance for both region sizes.

// File: rtl/wsr_pkg.sv
package wsr_pkg;

   typedef enum logic [1:0] {
      WS_IDLE   = 2'd0,
      WS_ACTIVE = 2'd1,
      WS_SUSP   = 2'd2,
      WS_RSVD   = 2'd3
   } ws_mode_e;

   localparam int unsigned POLL_BIT     = 7;
   localparam int unsigned TOG_BIT      = 6;
   localparam int unsigned SUSP_TOG_BIT = 2;

endpackage

// File: rtl/wsr_region.sv
module wsr_region #(
   parameter int unsigned AW        = 20,
   parameter int unsigned SECT_BITS = 11,
   parameter int unsigned BLK_BITS  = 15,
   parameter bit          BLOCK_EN  = 1'b1
) (
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] base,
   input  logic          blk,
   output logic          hit
);

   logic sect_hit;

   assign sect_hit = (addr >> SECT_BITS) == (base >> SECT_BITS);

   generate
      if (BLOCK_EN) begin : g_two_sizes
         logic blk_hit;
         assign blk_hit = (addr >> BLK_BITS) == (base >> BLK_BITS);
         assign hit     = blk ? blk_hit : sect_hit;
      end else begin : g_sector_only
         logic unused_blk;
         assign unused_blk = blk;
         assign hit        = sect_hit;
      end
   endgenerate

endmodule

// File: rtl/wsr_toggle.sv
module wsr_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_en,
   input  logic active,
   input  logic susp_hit,
   output logic tog6_now,
   output logic tog2_now
);

   logic rd_en_q;
   logic tog6_q;
   logic tog2_q;
   logic access_start;
   logic adv6;
   logic adv2;

   assign access_start = rd_en & ~rd_en_q;
   assign adv6         = access_start & active;
   assign adv2         = access_start & susp_hit;

   assign tog6_now = adv6 ? ~tog6_q : tog6_q;
   assign tog2_now = adv2 ? ~tog2_q : tog2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_en_q <= 1'b0;
         tog6_q  <= 1'b0;
         tog2_q  <= 1'b0;
      end else begin
         rd_en_q <= rd_en;
         tog6_q  <= tog6_now;
         tog2_q  <= tog2_now;
      end
   end

endmodule

// File: rtl/wsr_mux.sv
module wsr_mux
   import wsr_pkg::*;
#(
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  ws_mode_e      mode,
   input  logic          hit,
   input  logic          exp7,
   input  logic [DW-1:0] array_data,
   input  logic          tog6,
   input  logic          tog2,
   output logic [DW-1:0] rd_data
);

   logic [DW-1:0] act_word;
   logic [DW-1:0] sus_word;
   logic [DW-1:0] sel;

   for (genvar b = 0; b < DW; b++) begin : g_bits
      if (b == POLL_BIT) begin : g_poll
         assign act_word[b] = ~exp7;
         assign sus_word[b] = 1'b0;
      end else if (b == TOG_BIT) begin : g_tog
         assign act_word[b] = tog6;
         assign sus_word[b] = 1'b1;
      end else if (b == SUSP_TOG_BIT) begin : g_stog
         assign act_word[b] = 1'b0;
         assign sus_word[b] = tog2;
      end else begin : g_zero
         assign act_word[b] = 1'b0;
         assign sus_word[b] = 1'b0;
      end
   end

   always_comb begin
      case (mode)
         WS_ACTIVE: sel = act_word;
         WS_SUSP:   sel = hit ? sus_word : array_data;
         default:   sel = array_data;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= sel;
   end

endmodule

// File: rtl/wstat_rdmux.sv
module wstat_rdmux
   import wsr_pkg::*;
#(
   parameter int unsigned DW        = 16,
   parameter int unsigned AW        = 20,
   parameter int unsigned SECT_BITS = 11,
   parameter int unsigned BLK_BITS  = 15,
   parameter bit          BLOCK_EN  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    mode_i,
   input  logic          exp_d7_i,
   input  logic [AW-1:0] susp_base_i,
   input  logic          susp_blk_i,
   input  logic          rd_en_i,
   input  logic [AW-1:0] rd_addr_i,
   input  logic [DW-1:0] array_data_i,
   output logic [DW-1:0] rd_data_o,
   output logic          ready_o
);

   if (DW < 8) begin : g_bad_dw
      $error("wstat_rdmux: DW must be at least 8");
   end
   if (SECT_BITS < 1 || BLK_BITS < SECT_BITS) begin : g_bad_sizes
      $error("wstat_rdmux: need 1 <= SECT_BITS <= BLK_BITS");
   end
   if (BLK_BITS >= AW) begin : g_bad_aw
      $error("wstat_rdmux: BLK_BITS must be below AW");
   end

   ws_mode_e mode;
   logic     op_active;
   logic     op_susp;
   logic     region_hit;
   logic     tog6;
   logic     tog2;

   assign mode      = ws_mode_e'(mode_i);
   assign op_active = (mode == WS_ACTIVE);
   assign op_susp   = (mode == WS_SUSP);
   assign ready_o   = ~op_active;

   wsr_region #(
      .AW(AW), .SECT_BITS(SECT_BITS), .BLK_BITS(BLK_BITS), .BLOCK_EN(BLOCK_EN)
   ) u_region (
      .addr(rd_addr_i),
      .base(susp_base_i),
      .blk (susp_blk_i),
      .hit (region_hit)
   );

   wsr_toggle u_toggle (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en_i),
      .active  (op_active),
      .susp_hit(op_susp & region_hit),
      .tog6_now(tog6),
      .tog2_now(tog2)
   );

   wsr_mux #(.DW(DW)) u_mux (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (rd_en_i),
      .mode      (mode),
      .hit       (region_hit),
      .exp7      (exp_d7_i),
      .array_data(array_data_i),
      .tog6      (tog6),
      .tog2      (tog2),
      .rd_data   (rd_data_o)
   );

endmodule

// File: rtl/wstat_rdmux_chk.sv
module wstat_rdmux_chk #(
   parameter int unsigned DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    mode_i,
   input logic          exp_d7_i,
   input logic          rd_en_i,
   input logic          hit,
   input logic [DW-1:0] array_data_i,
   input logic [DW-1:0] rd_data_o,
   input logic          ready_o
);

   localparam logic [DW-1:0] ACT_KEEP = DW'(8'hC0);
   localparam logic [DW-1:0] SUS_KEEP = DW'(8'h44);

   assert_poll_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && mode_i == 2'd1) |=> (rd_data_o[7] != $past(exp_d7_i)));

   assert_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && $past(rd_en_i) && mode_i == 2'd1 && $past(mode_i) == 2'd1
       && $stable(exp_d7_i)) |=> $stable(rd_data_o));

   assert_zero_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && mode_i == 2'd1) |=> ((rd_data_o & ~ACT_KEEP) == '0));

   assert_susp_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && mode_i == 2'd2 && hit) |=>
         (rd_data_o[6] && ((rd_data_o & ~SUS_KEEP) == '0)));

   assert_susp_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && mode_i == 2'd2 && !hit) |=> (rd_data_o == $past(array_data_i)));

   assert_idle_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && (mode_i == 2'd0 || mode_i == 2'd3)) |=>
         (rd_data_o == $past(array_data_i)));

   assert_ready_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_o) |-> ($past(mode_i) == 2'd1));

   assert_ready_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready_o) |-> (mode_i == 2'd1));

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_i |=> $stable(rd_data_o));

endmodule

bind wstat_rdmux wstat_rdmux_chk #(.DW(DW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_i      (mode_i),
   .exp_d7_i    (exp_d7_i),
   .rd_en_i     (rd_en_i),
   .hit         (region_hit),
   .array_data_i(array_data_i),
   .rd_data_o   (rd_data_o),
   .ready_o     (ready_o)
);

// File: tb/wstat_rdmux_test.sv
module wstat_rdmux_test;

   localparam int DW = 16;
   localparam int AW = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    mode = 2'd0;
   logic          exp7 = 1'b0;
   logic [AW-1:0] sbase = '0;
   logic          sblk = 1'b0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] arr = '0;
   logic [DW-1:0] rd_data;
   logic          ready;

   int n_cmp = 0;
   int n_bad = 0;
   int cycles = 0;
   logic m6 = 1'b0;
   logic m2 = 1'b0;

   always #5 clk = ~clk;

   wstat_rdmux uut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .exp_d7_i(exp7),
      .susp_base_i(sbase), .susp_blk_i(sblk), .rd_en_i(rd_en),
      .rd_addr_i(addr), .array_data_i(arr), .rd_data_o(rd_data), .ready_o(ready)
   );

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] expv);
      n_cmp++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   function automatic logic in_region(input logic [AW-1:0] a);
      int sh = sblk ? 15 : 11;
      return (a >> sh) == (sbase >> sh);
   endfunction

   task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag, input int hold);
      logic [DW-1:0] e;
      @(negedge clk);
      addr = a; arr = d; rd_en = 1'b1;
      e = '0;
      case (mode)
         2'd1: begin m6 = ~m6; e[7] = ~exp7; e[6] = m6; end
         2'd2: if (in_region(a)) begin m2 = ~m2; e[6] = 1'b1; e[2] = m2; end
               else e = d;
         default: e = d;
      endcase
      @(negedge clk);
      check(tag, rd_data, e);
      for (int h = 0; h < hold; h++) begin
         @(negedge clk);
         check({tag, " held R3"}, rd_data, e);
      end
      rd_en = 1'b0;
      @(negedge clk);
      check({tag, " strobe low R9"}, rd_data, e);
   endtask

   task automatic set_mode(input logic [1:0] m);
      @(negedge clk);
      mode = m;
      #1 check("ready R8", {15'd0, ready}, {15'd0, (m != 2'd1)});
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("reset data R9", rd_data, '0);
      check("reset ready R8", {15'd0, ready}, 16'd1);
      rst_n = 1'b1;

      // R1: idle and code 3 pass array data
      for (int i = 0; i < 8; i++)
         rd(AW'(i * 4099), DW'((i * 16'h1357) ^ 16'hA5A5), "idle R1", i % 2);
      set_mode(2'd3);
      for (int i = 0; i < 4; i++)
         rd(AW'(i * 777), DW'(16'h0F0F + i * 16'h1111), "code3 R1", 0);

      // R2 R3 R4: active program, both polarities
      set_mode(2'd1);
      exp7 = 1'b1;
      for (int i = 0; i < 6; i++)
         rd(AW'(i * 12345), DW'(16'hFFFF), "active R2 R3 R4", (i == 2) ? 3 : 0);
      @(negedge clk); exp7 = 1'b0;
      for (int i = 0; i < 5; i++)
         rd(AW'(i * 50000 + 3), DW'(16'h1234), "active exp0 R2 R3", 0);

      // R2: whole-array erase, status at every block
      @(negedge clk); exp7 = 1'b1;
      for (int i = 0; i < 32; i++)
         rd(AW'(i * 32768 + i), DW'(16'hFFFF), "chip erase R2 R4", 0);

      // R5 R6 R7: suspended sector
      set_mode(2'd2);
      sbase = AW'(5 * 2048 + 100); sblk = 1'b0;
      for (int i = 0; i < 16; i++)
         rd(AW'(i * 2048 + i * 37), DW'(16'hC3A0 + i), "susp sector R5 R6 R7", 0);
      for (int i = 0; i < 3; i++)
         rd(AW'(5 * 2048 + 2047 - i), DW'(16'hBEEF), "susp in-sector R5", 1);

      // R7: suspended block
      @(negedge clk); sblk = 1'b1;
      for (int i = 0; i < 8; i++)
         rd(AW'(i * 32768 + 777), DW'(16'h5A00 + i), "susp block R7 R6", 0);
      for (int i = 0; i < 16; i++)
         rd(AW'(i * 2048 + 9), DW'(16'h7700 + i), "susp block sweep R5 R7", 0);

      // R10: active toggle resumes from its last value
      set_mode(2'd1);
      for (int i = 0; i < 3; i++)
         rd(AW'(i), DW'(16'h0000), "resume R10", 0);
      set_mode(2'd2);
      rd(AW'(5 * 2048), DW'(16'h1111), "suspend resume R10", 0);

      set_mode(2'd0);
      rd(AW'(42), DW'(16'hD00D), "done R1 R8", 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule